// File: doc/BRIEF.md
# Single-Byte I2C Target

This block is an I2C bus target for standard-mode traffic that carries exactly one data byte per transaction. It samples the SCL and SDA lines with the system clock, resynchronises them, and detects START, STOP and clock edges from the synchronised copies. When the address byte names this target, it acknowledges. It then either accepts one byte from the controller or returns one byte supplied by the surrounding core.

The 7-bit target address has a fixed five-bit upper part, 0b00111 by default. Two strap inputs supply the two low address bits, so a board can place up to four targets on one bus. SDA is open-drain: the block never drives it high. It offers a pull-low output for the pad's pull-down transistor and a complementary float output. A received byte appears on a data output together with a single-cycle valid strobe. A read returns the byte that sits on the transmit input at the moment the address acknowledge ends.

Top module: `i2c_byte_target`

## Requirements
- R1: After reset, sda_pull_low is 0, sda_float is 1, rx_valid is 0 and rx_data is 0.
- R2: The address byte is received MSB first, and its bits 7..1 are compared with {5'b00111, addr_strap[1], addr_strap[0]}. Bit 0 is the direction bit: 0 means a write to the target, 1 means a read. On a match, the target holds SDA low for the whole ninth clock.
- R3: On an address mismatch, the target drives SDA at no point until the next START, and it raises no rx_valid.
- R4: In a write, the data byte is taken MSB first and acknowledged low on its ninth clock. rx_data takes the byte, and rx_valid is high for exactly one clock cycle.
- R5: In a read, tx_data is captured at the falling SCL edge that ends the address acknowledge. It is sent MSB first: SDA is pulled low for a 0 bit and released for a 1 bit. Each bit changes only after a falling SCL edge.
- R6: After the eighth read bit, the target releases SDA for the controller's acknowledge bit. A NACK ends the transfer, and the target drives nothing further until the next START.
- R7: Only one data byte moves per transaction. After a written byte has been acknowledged, further clocks are not acknowledged and raise no second rx_valid. After a read byte, further read clocks return all ones.
- R8: A STOP at any point returns the target to idle, with SDA released, and the next transaction is served normally.
- R9: A repeated START at any point restarts address reception from the first bit.
- R10: sda_float is always the complement of sda_pull_low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line (wired-AND bus value) |
| addr_strap | input | 2 | Low two address bits: [1] is address bit 1, [0] is address bit 0 |
| tx_data | input | 8 | Byte returned on a read |
| rx_data | output | 8 | Last byte written by the controller |
| rx_valid | output | 1 | One-cycle strobe when rx_data is updated |
| sda_pull_low | output | 1 | 1 enables the SDA pull-down |
| sda_float | output | 1 | 1 when SDA is released |

## Verification
In a read, the falling SCL edge that closes the address acknowledge does two things in the same cycle: it ends the acknowledge and it launches bit 7 of the read byte. The bench provokes this with a read byte whose MSB is 0, so SDA must stay low from the acknowledge straight into the first data bit without a release in between. It judges the result by counting rising edges of sda_float across the whole read, which must equal the number of 0-to-1 steps in the expected bit stream. It also checks the byte value seen on the wired-AND line.

// File: rtl/i2cbt_pkg.sv
package i2cbt_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int STRAP_W = 2;
  localparam int PFX_W   = ADDR_W - STRAP_W;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK, ST_HOLD
  } tgt_state_e;

  // header byte carries the 7-bit address in bits 7..1
  function automatic logic addr_hit(input logic [BYTE_W-1:0]  hdr,
                                    input logic [PFX_W-1:0]   pfx,
                                    input logic [STRAP_W-1:0] strap);
    return hdr[BYTE_W-1:1] == {pfx, strap};
  endfunction
endpackage

// File: rtl/i2cbt_sync.sv
module i2cbt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cbt_bus_events.sv
module i2cbt_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cbt_fsm.sv
module i2cbt_fsm
  import i2cbt_pkg::*;
#(
  parameter logic [PFX_W-1:0] ADDR_PREFIX = 5'b00111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               sda_bit,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [BYTE_W-1:0]  tx_data,
  output logic [BYTE_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               drive_low
);
  tgt_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              rd_dir;

  // named internal events
  logic byte_full_w, hdr_done_w, wbyte_done_w, hit_w, rbit_next_w, rbyte_done_w;
  assign byte_full_w  = (cnt == CNT_W'(BYTE_W));
  assign hdr_done_w   = scl_fall && byte_full_w && (st == ST_ADDR);
  assign wbyte_done_w = scl_fall && byte_full_w && (st == ST_WDATA);
  assign hit_w        = addr_hit(sh, ADDR_PREFIX, addr_strap);
  assign rbit_next_w  = scl_fall && !byte_full_w && (st == ST_RDATA);
  assign rbyte_done_w = scl_fall && byte_full_w && (st == ST_RDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      rd_dir    <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      drive_low <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (stop_evt) begin
        st        <= ST_IDLE;
        cnt       <= '0;
        drive_low <= 1'b0;
      end else if (start_evt) begin
        st        <= ST_ADDR;
        cnt       <= '0;
        drive_low <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && !byte_full_w) begin
              sh  <= {sh[BYTE_W-2:0], sda_bit};
              cnt <= cnt + 1'b1;
            end else if (hdr_done_w) begin
              if (hit_w) begin
                st        <= ST_AACK;
                drive_low <= 1'b1;
                rd_dir    <= sh[0];
              end else begin
                st <= ST_IDLE;
              end
            end else if (wbyte_done_w) begin
              rx_data   <= sh;
              rx_valid  <= 1'b1;
              st        <= ST_WACK;
              drive_low <= 1'b1;
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rd_dir) begin
                st        <= ST_RDATA;
                sh        <= tx_data;
                drive_low <= ~tx_data[BYTE_W-1];
              end else begin
                st        <= ST_WDATA;
                drive_low <= 1'b0;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              st        <= ST_HOLD;
              drive_low <= 1'b0;
            end
          end
          ST_RDATA: begin
            if (scl_rise && !byte_full_w) begin
              cnt <= cnt + 1'b1;
            end else if (rbyte_done_w) begin
              st        <= ST_RACK;
              drive_low <= 1'b0;
            end else if (rbit_next_w) begin
              sh        <= {sh[BYTE_W-2:0], 1'b0};
              drive_low <= ~sh[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (scl_rise) st <= ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  // R4
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R4
  rx_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> drive_low);
  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!drive_low && st == ST_IDLE));
  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_ADDR && cnt == '0));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_HOLD) |-> !drive_low);
  // R5
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive_low) |-> $past(scl_fall || stop_evt || start_evt));
endmodule

// File: rtl/i2c_byte_target.sv
module i2c_byte_target
  import i2cbt_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [PFX_W-1:0]  ADDR_PREFIX = 5'b00111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [BYTE_W-1:0]  tx_data,
  output logic [BYTE_W-1:0]  rx_data,
  output logic               rx_valid,
  output logic               sda_pull_low,
  output logic               sda_float
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw, line_s;
  logic scl_rise, scl_fall, start_evt, stop_evt, drive_low;

  assign line_raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2cbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_raw[g]), .q(line_s[g])
    );
  end

  i2cbt_bus_events u_ev (
    .clk(clk), .rst_n(rst_n),
    .scl_s(line_s[0]), .sda_s(line_s[1]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2cbt_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_bit(line_s[1]), .addr_strap(addr_strap), .tx_data(tx_data),
    .rx_data(rx_data), .rx_valid(rx_valid), .drive_low(drive_low)
  );

  assign sda_pull_low = drive_low;
  assign sda_float    = ~drive_low;

  // R10
  float_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_float != sda_pull_low);
endmodule

// File: tb/sim_i2c_byte_target.sv
module sim_i2c_byte_target;
  localparam int Q  = 20;
  localparam int NV = 8;
  // {strap[1:0], addr7, rw, data}
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 7'h1C, 1'b0, 8'hA5},
    {2'b01, 7'h1D, 1'b0, 8'h3C},
    {2'b10, 7'h1E, 1'b1, 8'h96},
    {2'b11, 7'h1F, 1'b1, 8'h41},
    {2'b00, 7'h1D, 1'b0, 8'hFF},
    {2'b11, 7'h1C, 1'b1, 8'h00},
    {2'b10, 7'h5E, 1'b0, 8'h01},
    {2'b01, 7'h1D, 1'b1, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_strap = 2'b00;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic rx_valid, sda_pull_low, sda_float;
  logic sda_line;
  int tests = 0, fails = 0;
  int strobes = 0, drv_cnt = 0, rel_cnt = 0;
  logic [7:0] last_rx = 8'h00;
  logic float_q = 1'b1;
  logic done = 1'b0;

  assign sda_line = sda_m & ~sda_pull_low;

  always #4 clk = ~clk;

  i2c_byte_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_strap(addr_strap), .tx_data(tx_data), .rx_data(rx_data),
    .rx_valid(rx_valid), .sda_pull_low(sda_pull_low), .sda_float(sda_float)
  );

  always @(posedge clk) begin
    if (rx_valid) begin strobes <= strobes + 1; last_rx <= rx_data; end
    if (sda_pull_low) drv_cnt <= drv_cnt + 1;
    float_q <= sda_float;
    if (sda_float && !float_q) rel_cnt <= rel_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic half(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; half(); scl_m = 1; half(); sda_m = 0; half(); scl_m = 0; half(); endtask
  task automatic bus_stop(); sda_m = 0; half(); scl_m = 1; half(); sda_m = 1; half(); endtask
  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; half(); scl_m = 1; half(); seen = sda_line; half(); scl_m = 0; half();
  endtask
  task automatic send_byte(input logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
  endtask
  task automatic read_byte(output logic [7:0] v);
    logic s;
    v = '0;
    for (int i = 0; i < 8; i++) begin clk_bit(1'b1, s); v = {v[6:0], s}; end
  endtask

  function automatic logic is_mine(input logic [6:0] a, input logic [1:0] st);
    return a[6:2] == 5'b00111 && a[1] == st[1] && a[0] == st[0];
  endfunction

  initial begin
    logic [1:0] st; logic [6:0] a; logic rw; logic [7:0] d, v; logic ack, hit;
    int s0, d0, r0;
    repeat (10) @(negedge clk);
    // R1 reset state
    check(sda_pull_low == 0 && sda_float == 1, "R1 sda", {sda_pull_low, sda_float}, 2'b01);
    check(rx_valid == 0 && rx_data == 0, "R1 rx", {rx_valid, rx_data}, 0);
    rst_n = 1'b1;
    half();

    for (int i = 0; i < NV; i++) begin
      {st, a, rw, d} = VEC[i];
      addr_strap = st; tx_data = d;
      hit = is_mine(a, st);
      s0 = strobes; d0 = drv_cnt;
      bus_start(); send_byte({a, rw}); clk_bit(1'b1, ack);
      check(ack == !hit, hit ? "R2 ack" : "R3 noack", ack, !hit);
      if (hit && !rw) begin
        send_byte(d); clk_bit(1'b1, ack);
        check(ack == 0, "R4 data ack", ack, 0);
        check(strobes == s0 + 1 && last_rx == d, "R4 strobe", {strobes[7:0], last_rx}, {8'(s0 + 1), d});
      end else if (hit) begin
        read_byte(v);
        check(v == d, "R5 read", v, d);
        clk_bit(1'b1, ack);
        check(strobes == s0, "R5 no strobe", strobes, s0);
      end else begin
        send_byte(8'hFF); clk_bit(1'b1, ack);
        check(drv_cnt == d0 && strobes == s0, "R3 quiet", {drv_cnt[15:0], strobes[15:0]}, {d0[15:0], s0[15:0]});
      end
      bus_stop(); half();
      check(sda_pull_low == 0 && sda_float == 1, "R10 R8 idle", {sda_pull_low, sda_float}, 2'b01);
    end

    // R7: second written byte not acknowledged, no second strobe
    addr_strap = 2'b00; s0 = strobes;
    bus_start(); send_byte({7'h1C, 1'b0}); clk_bit(1'b1, ack);
    send_byte(8'hC3); clk_bit(1'b1, ack);
    send_byte(8'h55); clk_bit(1'b1, ack);
    check(ack == 1, "R7 extra noack", ack, 1);
    check(strobes == s0 + 1 && last_rx == 8'hC3, "R7 one strobe", {strobes[7:0], last_rx}, {8'(s0 + 1), 8'hC3});
    bus_stop(); half();

    // R6/R7: master ACKs the read byte, further reads give all ones
    addr_strap = 2'b10; tx_data = 8'h18;
    bus_start(); send_byte({7'h1E, 1'b1}); clk_bit(1'b1, ack);
    read_byte(v); clk_bit(1'b0, ack);
    d0 = drv_cnt;
    read_byte(v);
    check(v == 8'hFF && drv_cnt == d0, "R6 R7 no second byte", {v, drv_cnt[7:0]}, {8'hFF, d0[7:0]});
    bus_stop(); half();

    // R8: STOP inside the address byte, then a normal transaction
    addr_strap = 2'b01; s0 = strobes;
    bus_start(); clk_bit(0, ack); clk_bit(0, ack); clk_bit(1, ack);
    bus_stop(); half();
    check(sda_pull_low == 0, "R8 stop idle", sda_pull_low, 0);
    bus_start(); send_byte({7'h1D, 1'b0}); clk_bit(1'b1, ack);
    check(ack == 0, "R8 next ack", ack, 0);
    send_byte(8'h96); clk_bit(1'b1, ack); bus_stop(); half();
    check(strobes == s0 + 1 && last_rx == 8'h96, "R8 next write", last_rx, 8'h96);

    // R9: repeated START mid-address restarts reception
    addr_strap = 2'b11; s0 = strobes;
    bus_start(); clk_bit(1, ack); clk_bit(0, ack); clk_bit(1, ack); clk_bit(1, ack);
    bus_start(); send_byte({7'h1F, 1'b0}); clk_bit(1'b1, ack);
    check(ack == 0, "R9 ack after restart", ack, 0);
    send_byte(8'h5A); clk_bit(1'b1, ack); bus_stop(); half();
    check(strobes == s0 + 1 && last_rx == 8'h5A, "R9 write", last_rx, 8'h5A);

    // R5: ack end and MSB-0 launch in one edge; bits ack,0,1,0,0,0,0,0,1 -> 2 releases
    addr_strap = 2'b11; tx_data = 8'h41;
    bus_start(); send_byte({7'h1F, 1'b1});
    r0 = rel_cnt;
    clk_bit(1'b1, ack); read_byte(v); clk_bit(1'b1, ack);
    check(v == 8'h41, "R5 msb0 read", v, 8'h41);
    check(rel_cnt == r0 + 2, "R5 release count", rel_cnt, r0 + 2);
    bus_stop(); half();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule